// File: doc/BRIEF.md
# Emergency Malfunction Pulse Generator

This block tells the host that an internal emergency has struck a drive that was ready. An emergency request sets an unload latch. That latch at once pulls the internal ready level low. A delayed copy of ready follows ready up immediately. It follows ready down only after a programmable number of clock cycles. The host-facing malfunction line is the overlap of the unload latch and the delayed ready level. Its pulse width is therefore the lag of the delayed-ready path, and no separate pulse timer is needed.

The latch stays set until reset or an explicit clear. While it is set, ready stays low whatever the drive reports, so one setting of the latch can produce only one pulse. The block does not detect the emergency conditions and does not handle the unload mechanics.

Top module: `malfPulseGen`

## Requirements
- R1: While reset is held, and after it is released, the unload latch is clear and `malfunction` is 0. `readyOut` and `dlyReadyOut` both equal `driveReady`.
- R2: `emergReq` sampled high at a rising edge (with `clearReq` low) sets the unload latch. From that edge on, `readyOut` is 0 regardless of `driveReady`.
- R3: If `readyOut` was 1 at that edge, `malfunction` is 1 for exactly DELAY_CYCLES cycles (default 8), starting right after the edge.
- R4: When `readyOut` falls, `dlyReadyOut` stays 1 for DELAY_CYCLES cycles and then drops to 0.
- R5: `dlyReadyOut` rises in the same cycle as `readyOut` rises, with no delay.
- R6: An emergency that arrives after `readyOut` has been low for at least DELAY_CYCLES cycles produces no pulse. If it arrives sooner, the pulse lasts only for the rest of the delay window.
- R7: Once set, the latch stays set until reset or `clearReq`. It gives no further pulse even if `driveReady` toggles.
- R8: `clearReq` sampled high clears the latch and wins over an `emergReq` in the same cycle. After the clear, `readyOut` follows `driveReady` again and `malfunction` is 0.
- R9: An emergency after a clear, with the drive ready again, produces a new pulse of full width.
- R10: A drop of `driveReady` with no emergency delays `dlyReadyOut` as in R4 but never raises `malfunction`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| driveReady | input | 1 | Ready condition reported by the drive |
| emergReq | input | 1 | Emergency request, sampled each rising edge |
| clearReq | input | 1 | Clears the unload latch |
| readyOut | output | 1 | Internal ready: drive ready and latch clear |
| dlyReadyOut | output | 1 | Ready with its falling edge delayed |
| malfunction | output | 1 | Malfunction-detected pulse to the host |

## Verification
The bench measures the pulse width with a small delay and with the default delay. An off-by-one in the delay counter shows up there as a pulse one cycle short or long. It raises `driveReady` again after a pulse, because a latch that failed to hold ready low would then fire a second pulse. It also issues an emergency long after ready fell, which a design keying off ready instead of the delayed copy would wrongly report. Finally, it asserts clear and request together, where the wrong priority leaves the drive stuck not-ready.

// File: rtl/malfPulse_pkg.sv
package malfPulse_pkg;
  typedef struct packed {
    logic cntRestart;  // ready high: window restarts
    logic cntAdvance;  // ready low: window runs down
  } delayStrobe_t;
endpackage

// File: rtl/malfPulseCtrl.sv
module malfPulseCtrl
  import malfPulse_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         driveReady,
  input  logic         emergReq,
  input  logic         clearReq,
  input  logic         inWindow,
  output delayStrobe_t strobes,
  output logic         readyNow,
  output logic         malfunction
);
  logic unloadLatch;

  always_ff @(posedge clk) begin
    if (!rstN)         unloadLatch <= 1'b0;
    else if (clearReq) unloadLatch <= 1'b0;
    else if (emergReq) unloadLatch <= 1'b1;
  end

  always_comb begin
    readyNow           = driveReady & ~unloadLatch;
    strobes.cntRestart = readyNow;
    strobes.cntAdvance = ~readyNow;
    malfunction        = unloadLatch & inWindow;
  end
endmodule

// File: rtl/malfPulseDelay.sv
module malfPulseDelay
  import malfPulse_pkg::*;
#(
  parameter int DELAY_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  delayStrobe_t strobes,
  output logic         inWindow
);
  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYCLES);

  logic [CNT_W-1:0] lowCount;

  // Resets saturated so a not-ready drive shows no stale window.
  always_ff @(posedge clk) begin
    if (!rstN)                                    lowCount <= LIMIT;
    else if (strobes.cntRestart)                  lowCount <= '0;
    else if (strobes.cntAdvance && lowCount != LIMIT) lowCount <= lowCount + 1'b1;
  end

  assign inWindow = (lowCount != LIMIT);
endmodule

// File: rtl/malfPulseGen.sv
module malfPulseGen
  import malfPulse_pkg::*;
#(
  parameter int DELAY_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic driveReady,
  input  logic emergReq,
  input  logic clearReq,
  output logic readyOut,
  output logic dlyReadyOut,
  output logic malfunction
);
  delayStrobe_t strobes;
  logic inWindow;
  logic readyNow;

  malfPulseCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .driveReady(driveReady), .emergReq(emergReq),
    .clearReq(clearReq), .inWindow(inWindow), .strobes(strobes),
    .readyNow(readyNow), .malfunction(malfunction)
  );

  malfPulseDelay #(.DELAY_CYCLES(DELAY_CYCLES)) delay_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inWindow(inWindow)
  );

  assign readyOut    = readyNow;
  assign dlyReadyOut = readyNow | inWindow;  // rise is immediate (R5)
endmodule

// File: rtl/malfPulseChk.sv
module malfPulseChk (
  input logic clk,
  input logic rstN,
  input logic emergReq,
  input logic clearReq,
  input logic readyOut,
  input logic dlyReadyOut,
  input logic malfunction
);
  a_r5_dly_covers_ready: assert property (@(posedge clk) disable iff (!rstN)
    readyOut |-> dlyReadyOut);

  a_r2_pulse_only_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    malfunction |-> !readyOut);

  a_r3_pulse_starts: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && emergReq && !clearReq) |=> malfunction);

  a_r6_no_late_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && !dlyReadyOut) |=> !malfunction);

  a_r8_clear_ends_pulse: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> !malfunction);
endmodule

bind malfPulseGen malfPulseChk chk_i (
  .clk(clk), .rstN(rstN), .emergReq(emergReq), .clearReq(clearReq),
  .readyOut(readyOut), .dlyReadyOut(dlyReadyOut), .malfunction(malfunction)
);

// File: tb/malfPulseGen_tb_top.sv
module malfPulseGen_tb_top;
  localparam int TB_DELAY = 3;
  localparam int NVEC = 24;
  // [9:6] requirement, [5] driveReady, [4] emergReq, [3] clearReq,
  // [2] exp readyOut, [1] exp dlyReadyOut, [0] exp malfunction
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd5,  6'b100_110},  // 0  R5 ready rises, dly with it
    {4'd2,  6'b110_110},  // 1  R2 emergency sampled at this edge
    {4'd3,  6'b100_011},  // 2  R3 pulse cycle 1
    {4'd3,  6'b100_011},  // 3  R3 pulse cycle 2
    {4'd3,  6'b100_011},  // 4  R3 pulse cycle 3
    {4'd3,  6'b100_000},  // 5  R3 pulse over after DELAY
    {4'd7,  6'b000_000},  // 6  R7 latch held
    {4'd7,  6'b100_000},  // 7  R7 no second pulse on ready toggle
    {4'd8,  6'b101_000},  // 8  R8 clear sampled here
    {4'd8,  6'b100_110},  // 9  R8 ready follows drive again
    {4'd10, 6'b000_010},  // 10 R10 drive drop, dly held
    {4'd4,  6'b000_010},  // 11 R4
    {4'd4,  6'b000_010},  // 12 R4
    {4'd4,  6'b000_000},  // 13 R4 dly falls after DELAY
    {4'd6,  6'b010_000},  // 14 R6 late emergency
    {4'd6,  6'b100_000},  // 15 R6 no pulse, latch holds ready low
    {4'd8,  6'b111_000},  // 16 R8 clear with request
    {4'd8,  6'b100_110},  // 17 R8 clear won
    {4'd8,  6'b111_110},  // 18 R8 clear wins while ready
    {4'd8,  6'b100_110},  // 19 R8 still ready
    {4'd6,  6'b010_010},  // 20 R6 emergency as ready falls
    {4'd6,  6'b000_011},  // 21 R6 partial pulse
    {4'd6,  6'b000_011},  // 22 R6 partial pulse
    {4'd6,  6'b000_000}   // 23 R6 window done
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic driveReady = 1'b0, emergReq = 1'b0, clearReq = 1'b0;
  logic readyOut, dlyReadyOut, malfunction;
  logic dr8 = 1'b0, er8 = 1'b0, cr8 = 1'b0;
  logic ready8, dly8, mal8;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  malfPulseGen #(.DELAY_CYCLES(TB_DELAY)) dut_i (
    .clk(clk), .rstN(rstN), .driveReady(driveReady), .emergReq(emergReq),
    .clearReq(clearReq), .readyOut(readyOut), .dlyReadyOut(dlyReadyOut),
    .malfunction(malfunction)
  );

  malfPulseGen dut8_i (
    .clk(clk), .rstN(rstN), .driveReady(dr8), .emergReq(er8),
    .clearReq(cr8), .readyOut(ready8), .dlyReadyOut(dly8),
    .malfunction(mal8)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic measurePulse(input string req, output int width);
    width = 0;
    @(negedge clk); er8 = 1'b1;
    @(negedge clk); er8 = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (mal8) width++;
      @(negedge clk);
    end
  endtask

  initial begin
    int w;
    // R1 reset state
    driveReady = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "mal in reset", malfunction, 0);
    check("R1", "ready in reset", readyOut, 1);
    check("R1", "dly in reset", dlyReadyOut, 1);
    driveReady = 1'b0;
    #1;
    check("R1", "dly in reset low", dlyReadyOut, 0);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1", "dly after reset", dlyReadyOut, 0);
    check("R1", "mal after reset", malfunction, 0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      @(negedge clk);
      tag = $sformatf("R%0d row%0d", VEC[i][9:6], i);
      driveReady = VEC[i][5];
      emergReq   = VEC[i][4];
      clearReq   = VEC[i][3];
      #1;
      check(tag, "readyOut", readyOut, VEC[i][2]);
      check(tag, "dlyReadyOut", dlyReadyOut, VEC[i][1]);
      check(tag, "malfunction", malfunction, VEC[i][0]);
    end

    // R3 / R9 with the default delay of 8
    dr8 = 1'b1;
    repeat (3) @(negedge clk);
    measurePulse("R3", w);
    check("R3", "default pulse width", w, 8);
    check("R7", "ready held low", ready8, 0);
    cr8 = 1'b1; @(negedge clk); cr8 = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "ready back after clear", ready8, 1);
    measurePulse("R9", w);
    check("R9", "second pulse width", w, 8);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule